// File: doc/BRIEF.md
# Deferred Condition-Flag Evaluator

This block regenerates the four condition flags (negative, zero, carry, overflow) from a deferred flag record instead of from stored flag bits. A processor model that writes flags lazily keeps only a 4-bit operation tag and three operand words from the last flag-setting operation. When a consumer needs the flags, it presents that record to this block. The block rebuilds the result that the tagged operation would have produced and derives each flag from it, using the carry and overflow rule that belongs to that operation.

The record is sampled on every clock. One cycle later the flags appear packed in the top nibble of a data word, and an error strobe marks records that are malformed. A generate option removes the output register for callers that want the evaluation purely combinational.

Top module: `flag_thunk_eval`

## Requirements
- R1: While `rst_n` is low, `flags_word` and `thunk_err` are 0 whatever the inputs.
- R2: Tag encoding is COPY=0, ADD=1, SUB=2, ADC=3, SBB=4, LOGIC=5, MUL=6, MULL=7. For COPY, bits 31, 30, 29 and 28 of `thunk_a` are passed to N, Z, C and V. All other bits of `thunk_a`, and all of `thunk_b` and `thunk_c`, have no effect.
- R3: For ADD the result is a+b modulo 2^32. C=1 when the result is unsigned-below a. V is bit 31 of (res^a)&(res^b).
- R4: For SUB the result is a-b. C=1 when a>=b unsigned. V is bit 31 of (a^b)&(a^res).
- R5: For ADC, `thunk_c` is the old carry (0 or 1) and the result is a+b+c. C is (res<=a) when c=1 and (res<a) when c=0. V uses the ADD formula on this result.
- R6: For SBB the result is a-b-(c XOR 1). C is (a>=b) when c=1 and (a>b) when c=0. V uses the SUB formula on this result.
- R7: For LOGIC the result is `thunk_a`, C is `thunk_b` bit 0, and V is `thunk_c` bit 0.
- R8: For MUL the result is `thunk_a`, C is `thunk_c` bit 1, and V is `thunk_c` bit 0.
- R9: For MULL, `thunk_a` is the low half and `thunk_b` the high half. N is bit 31 of the high half. Z=1 only when both halves are zero. C and V come from `thunk_c` as in R8.
- R10: For every tag other than COPY and MULL, N is bit 31 of the result and Z=1 when the result is zero. Bits 27:0 of `flags_word` are always 0.
- R11: Tags 8..15, an ADC/SBB `thunk_c` above 1, and a MUL/MULL `thunk_c` above 3 are illegal. In the cycle that reports such a record, `thunk_err` is 1 and `flags_word` is 0.
- R12: With the default registered output, a record sampled at one rising edge is reported from that edge until the next one. `thunk_err` therefore lasts exactly one cycle per illegal record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thunk_op | input | 4 | Operation tag of the deferred record |
| thunk_a | input | DATA_W | First operand word |
| thunk_b | input | DATA_W | Second operand word |
| thunk_c | input | DATA_W | Third word: old carry, or old carry and old overflow |
| flags_word | output | DATA_W | N, Z, C, V in bits 31..28, zeros below |
| thunk_err | output | 1 | Illegal-record strobe |

## Verification
On every cycle, the assertions check four things: the pass-through of the COPY nibble, the subtract carry against an unsigned compare, the double-width zero test of MULL, and the rule that an illegal tag raises the strobe with the flags held at zero. The carry edge cases need the bench's scenarios: ADC at an all-ones sum with carry in, SBB with equal operands for each old-carry value, and signed overflow at the 0x7FFFFFFF/0x80000000 boundary. The bench also runs a long random mix of legal and malformed records, each compared against a reference model.

// File: rtl/flag_thunk_pkg.sv
package flag_thunk_pkg;
   localparam int TAG_W    = 4;
   localparam int FLAG_CNT = 4;

   typedef enum logic [TAG_W-1:0] {
      TK_COPY  = 4'd0,
      TK_ADD   = 4'd1,
      TK_SUB   = 4'd2,
      TK_ADC   = 4'd3,
      TK_SBB   = 4'd4,
      TK_LOGIC = 4'd5,
      TK_MUL   = 4'd6,
      TK_MULL  = 4'd7
   } thunk_tag_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;
endpackage

// File: rtl/flag_thunk_adder.sv
module flag_thunk_adder
   import flag_thunk_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [TAG_W-1:0]  op,
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   input  logic              carry_in,
   output logic [DATA_W-1:0] sum,
   output logic              carry_out,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   logic              is_sub;
   logic              cin;
   logic [DATA_W-1:0] rhs_eff;
   logic [DATA_W:0]   wide;

   // Subtraction is lhs + ~rhs + cin; SUB always carries in, SBB uses old carry
   always_comb begin
      is_sub  = (op == TK_SUB) || (op == TK_SBB);
      unique case (op)
         TK_ADD:  cin = 1'b0;
         TK_SUB:  cin = 1'b1;
         default: cin = carry_in;
      endcase
      rhs_eff   = is_sub ? ~rhs : rhs;
      wide      = {1'b0, lhs} + {1'b0, rhs_eff} + {{DATA_W{1'b0}}, cin};
      sum       = wide[MSB:0];
      carry_out = wide[DATA_W];
      ovf       = (lhs[MSB] == rhs_eff[MSB]) && (sum[MSB] != lhs[MSB]);
   end
endmodule

// File: rtl/flag_thunk_legal.sv
module flag_thunk_legal
   import flag_thunk_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [TAG_W-1:0]  op,
   input  logic [DATA_W-1:0] aux,
   output logic              bad
);
   localparam int MAX_TAG = 7;

   logic carry_word_bad;
   logic pair_word_bad;

   always_comb begin
      carry_word_bad = |aux[DATA_W-1:1];
      pair_word_bad  = |aux[DATA_W-1:2];
      if (int'(op) > MAX_TAG)
         bad = 1'b1;
      else if (op == TK_ADC || op == TK_SBB)
         bad = carry_word_bad;
      else if (op == TK_MUL || op == TK_MULL)
         bad = pair_word_bad;
      else
         bad = 1'b0;
   end
endmodule

// File: rtl/flag_thunk_core.sv
module flag_thunk_core
   import flag_thunk_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [TAG_W-1:0]  op,
   input  logic [DATA_W-1:0] wa,
   input  logic [DATA_W-1:0] wb,
   input  logic [DATA_W-1:0] wc,
   output nzcv_t             flags,
   output logic              bad
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] sum;
   logic              add_c;
   logic              add_v;
   logic [DATA_W-1:0] res;

   flag_thunk_adder #(.DATA_W(DATA_W)) u_add (
      .op(op), .lhs(wa), .rhs(wb), .carry_in(wc[0]),
      .sum(sum), .carry_out(add_c), .ovf(add_v)
   );

   flag_thunk_legal #(.DATA_W(DATA_W)) u_legal (
      .op(op), .aux(wc), .bad(bad)
   );

   always_comb begin
      res   = wa;
      flags = '0;
      unique case (op)
         TK_COPY: begin
            flags = nzcv_t'(wa[MSB -: FLAG_CNT]);
         end
         TK_ADD, TK_SUB, TK_ADC, TK_SBB: begin
            res     = sum;
            flags.n = res[MSB];
            flags.z = (res == '0);
            flags.c = add_c;
            flags.v = add_v;
         end
         TK_LOGIC: begin
            flags.n = res[MSB];
            flags.z = (res == '0);
            flags.c = wb[0];
            flags.v = wc[0];
         end
         TK_MUL: begin
            flags.n = res[MSB];
            flags.z = (res == '0);
            flags.c = wc[1];
            flags.v = wc[0];
         end
         TK_MULL: begin
            flags.n = wb[MSB];
            flags.z = ((wa | wb) == '0);
            flags.c = wc[1];
            flags.v = wc[0];
         end
         default: flags = '0;
      endcase
      if (bad) flags = '0;
   end
endmodule

// File: rtl/flag_thunk_eval.sv
module flag_thunk_eval
   import flag_thunk_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        thunk_op,
   input  logic [DATA_W-1:0] thunk_a,
   input  logic [DATA_W-1:0] thunk_b,
   input  logic [DATA_W-1:0] thunk_c,
   output logic [DATA_W-1:0] flags_word,
   output logic              thunk_err
);
   localparam int MSB    = DATA_W - 1;
   localparam int LOW_W  = DATA_W - FLAG_CNT;

   if (DATA_W < 8) begin : g_width_bad
      $error("flag_thunk_eval: DATA_W must be at least 8");
   end

   nzcv_t             flags_c;
   logic              bad_c;
   logic [DATA_W-1:0] word_c;

   flag_thunk_core #(.DATA_W(DATA_W)) u_core (
      .op(thunk_op), .wa(thunk_a), .wb(thunk_b), .wc(thunk_c),
      .flags(flags_c), .bad(bad_c)
   );

   assign word_c = {flags_c, {LOW_W{1'b0}}};

   if (REG_OUT) begin : g_reg
      logic [DATA_W-1:0] word_q;
      logic              err_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
            err_q  <= 1'b0;
         end else begin
            word_q <= word_c;
            err_q  <= bad_c;
         end
      end

      assign flags_word = word_q;
      assign thunk_err  = err_q;

      // R2
      copy_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(thunk_op) == 4'd0)
            |-> (flags_word[MSB -: FLAG_CNT] == $past(thunk_a[MSB -: FLAG_CNT])));

      // R4
      sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(thunk_op) == 4'd2)
            |-> (flags_word[MSB-2] == ($past(thunk_a) >= $past(thunk_b))));

      // R9
      mull_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(thunk_op) == 4'd7 && $past(thunk_c) < 4)
            |-> (flags_word[MSB-1] == (($past(thunk_a) | $past(thunk_b)) == '0)));

      // R11
      illegal_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(thunk_op) > 4'd7) |-> (thunk_err && flags_word == '0));

      // R11
      err_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
         thunk_err |-> (flags_word == '0));
   end else begin : g_comb
      assign flags_word = word_c;
      assign thunk_err  = bad_c;
   end
endmodule

// File: tb/flag_thunk_eval_test.sv
module flag_thunk_eval_test;
   localparam int CLK_PERIOD = 10;
   localparam int RAND_STEPS = 3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  thunk_op = '0;
   logic [31:0] thunk_a = '0;
   logic [31:0] thunk_b = '0;
   logic [31:0] thunk_c = '0;
   logic [31:0] flags_word;
   logic        thunk_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [32:0] exp_prev;
   logic [3:0]  op_prev;
   bit          have_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flag_thunk_eval uut (
      .clk(clk), .rst_n(rst_n), .thunk_op(thunk_op),
      .thunk_a(thunk_a), .thunk_b(thunk_b), .thunk_c(thunk_c),
      .flags_word(flags_word), .thunk_err(thunk_err)
   );

   // Reference: returns {err, packed word}
   function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
                                         input logic [31:0] b, input logic [31:0] c);
      logic [31:0] r;
      bit n, z, cf, v;
      n = 0; z = 0; cf = 0; v = 0;
      if (op > 7) return {1'b1, 32'h0};
      if ((op == 3 || op == 4) && c > 1) return {1'b1, 32'h0};
      if ((op == 6 || op == 7) && c > 3) return {1'b1, 32'h0};
      case (op)
         0: begin n = a[31]; z = a[30]; cf = a[29]; v = a[28]; r = a; end
         1: begin r = a + b; cf = (r < a); v = ((r ^ a) & (r ^ b)) >> 31; end
         2: begin r = a - b; cf = (a >= b); v = ((a ^ b) & (a ^ r)) >> 31; end
         3: begin r = a + b + c; cf = c[0] ? (r <= a) : (r < a);
                  v = ((r ^ a) & (r ^ b)) >> 31; end
         4: begin r = a - b - (c ^ 1); cf = c[0] ? (a >= b) : (a > b);
                  v = ((a ^ b) & (a ^ r)) >> 31; end
         5: begin r = a; cf = b[0]; v = c[0]; end
         6: begin r = a; cf = c[1]; v = c[0]; end
         default: begin r = b; cf = c[1]; v = c[0]; end
      endcase
      if (op != 0) begin
         n = r[31];
         z = (op == 7) ? ((a | b) == 0) : (r == 0);
      end
      return {1'b0, n, z, cf, v, 28'h0};
   endfunction

   function automatic string req_of(input logic [3:0] op, input bit err);
      if (err) return "R11";
      case (op)
         0: return "R2";  1: return "R3";  2: return "R4";  3: return "R5";
         4: return "R6";  5: return "R7";  6: return "R8";  default: return "R9";
      endcase
   endfunction

   // R12: outputs sampled one cycle after the inputs were driven
   task automatic compare_prev();
      if (!have_prev) return;
      checks++;
      if ({thunk_err, flags_word} !== exp_prev) begin
         fails++;
         $display("FAIL %s op=%0d actual err=%0b word=%08h expected err=%0b word=%08h",
                  req_of(op_prev, exp_prev[32]), op_prev, thunk_err, flags_word,
                  exp_prev[32], exp_prev[31:0]);
      end
      checks++;
      if (flags_word[27:0] !== 28'h0) begin // R10
         fails++;
         $display("FAIL R10 low bits actual %07h expected 0000000", flags_word[27:0]);
      end
   endtask

   task automatic step(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c);
      @(negedge clk);
      compare_prev();
      thunk_op = op; thunk_a = a; thunk_b = b; thunk_c = c;
      exp_prev  = model(op, a, b, c);
      op_prev   = op;
      have_prev = 1'b1;
   endtask

   initial begin
      thunk_op = 4'd1; thunk_a = 32'hFFFF_FFFF; thunk_b = 32'h1; thunk_c = 32'h0;
      repeat (3) @(negedge clk);
      checks++; // R1
      if (flags_word !== 32'h0 || thunk_err !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset actual err=%0b word=%08h expected err=0 word=00000000",
                  thunk_err, flags_word);
      end
      rst_n = 1'b1;
      // R2 copy with junk below the nibble
      step(0, 32'hA5FF_FFFF, 32'hDEAD_BEEF, 32'h1234);
      step(0, 32'h5000_0001, 32'h0, 32'hFFFF_FFFF);
      // R3 add boundaries
      step(1, 32'hFFFF_FFFF, 32'h1, 0);
      step(1, 32'h7FFF_FFFF, 32'h1, 0);
      step(1, 32'h8000_0000, 32'h8000_0000, 0);
      // R4 sub boundaries
      step(2, 32'h1234, 32'h1234, 0);
      step(2, 32'h8000_0000, 32'h1, 0);
      step(2, 32'h1, 32'h2, 0);
      // R5 adc with carry in
      step(3, 32'hFFFF_FFFF, 32'h0, 1);
      step(3, 32'hFFFF_FFFF, 32'h0, 0);
      step(3, 32'h7FFF_FFFF, 32'h0, 1);
      // R6 sbb equal operands, both old-carry values
      step(4, 32'h55, 32'h55, 0);
      step(4, 32'h55, 32'h55, 1);
      step(4, 32'h8000_0000, 32'h0, 0);
      // R7 logic
      step(5, 32'h0, 32'h1, 32'h1);
      step(5, 32'h8000_0000, 32'h0, 32'h0);
      // R8 mul
      step(6, 32'h0, 32'hFFFF, 32'h2);
      step(6, 32'h9000_0000, 32'h0, 32'h1);
      // R9 mull
      step(7, 32'h0, 32'h0, 32'h3);
      step(7, 32'h1, 32'h0, 32'h0);
      step(7, 32'h0, 32'h8000_0000, 32'h2);
      // R11 illegal records, each followed by a legal one
      step(9, 32'hFFFF_FFFF, 32'h0, 0);
      step(1, 32'h1, 32'h1, 0);
      step(3, 32'h1, 32'h1, 32'h2);
      step(6, 32'h1, 32'h1, 32'h4);
      step(15, 32'h0, 32'h0, 0);
      step(4, 32'h3, 32'h1, 32'h1);
      for (int i = 0; i < RAND_STEPS; i++) begin
         logic [3:0]  rop;
         logic [31:0] ra, rb, rc;
         rop = ($urandom_range(0, 9) < 9) ? 4'($urandom_range(0, 7)) : 4'($urandom_range(8, 15));
         ra  = $urandom();
         rb  = $urandom();
         if ($urandom_range(0, 7) == 0) rb = ra;
         rc  = ($urandom_range(0, 15) == 0) ? $urandom() : 32'($urandom_range(0, 3));
         if (rop <= 4 && $urandom_range(0, 3) == 0) rc = 32'($urandom_range(0, 1));
         step(rop, ra, rb, rc);
      end
      step(0, 0, 0, 0);
      @(negedge clk);
      compare_prev();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule